// File: doc/BRIEF.md
# One-Hot Vector Address Sequencer

This block turns one byte of a vector address into a series of register selects. Each bit of the loaded byte marks one byte-wide register that a controller wants to update. The block holds the byte in an internal vector register. On each clock it emits a one-hot select for the highest bit that is still set, then clears that bit. When no bits remain, it tells the controller that the byte has been fully served.

A controller pulses the load strobe with a new byte while the block is idle. It then moves one data byte per cycle into whichever register the select output names. When done rises, it fetches the next vector byte. An all-zero byte produces no selects and reports done at once. A byte with i set bits occupies the block for exactly i cycles.

The select is not found with a priority encoder. A registered mask is computed alongside the vector register instead. The mask is high from the top bit down to the highest set bit and low below it. The select is the XOR of adjacent mask bits, with the bottom bit gated by the bottom vector bit.

Top module: `vector_addr_sequencer`

## Requirements
- R1: While rst is high at a clock edge, the block clears its vector and mask state. After that edge done_o is 0, sel_valid_o is 0 and sel_o is all zeros.
- R2: A load_i pulse is accepted at a clock edge when no set bits remain in the vector register, including right after done has risen. The loaded byte's set bits start appearing on sel_o in the next cycle.
- R3: Whenever sel_valid_o is 1, sel_o has exactly one bit set. Whenever sel_valid_o is 0, sel_o is all zeros.
- R4: The selects for a loaded byte appear on consecutive cycles, one per cycle, in order from the most significant set bit (bit 7) to the least significant (bit 0). A byte with i set bits yields exactly i valid cycles.
- R5: Each served bit is cleared from the vector register at the clock edge that ends its select cycle. The XOR of all selects emitted for a byte equals that byte.
- R6: In the cycle after the last select, done_o is 1 and sel_valid_o is 0. After an all-zero byte is loaded, done_o is 1 in the very next cycle and no select is emitted. done_o stays 1 while the block is idle.
- R7: A load_i pulse that arrives while selects are still pending is ignored. The pending selects continue unchanged and the new byte is not captured.
- R8: done_o is 0 for the whole time a sequence is in progress, and done_o and sel_valid_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe for a new vector byte |
| vec_i | input | 8 | Vector byte; a set bit marks a register to update |
| sel_o | output | 8 | One-hot register select |
| sel_valid_o | output | 1 | sel_o names a register this cycle |
| done_o | output | 1 | All set bits of the last accepted byte have been served |

## Verification
Suppose the mask register falls out of step with the vector register. A select would then show two bits, no bits, or a bit below the one that should be served. This shows up on sel_o in the first cycle after the load, or the cycle after the bad update.

A bit that is not cleared shows up as a repeated select or a sequence that never ends. An extra clear shows up as a missing select and an early done. The bench detects both by counting valid cycles against the popcount of the byte.

If a load is taken while busy, later selects no longer XOR back to the original byte. The bench detects this as soon as that sequence ends.

// File: rtl/vas_pkg.sv
package vas_pkg;
  // Default vector width: one bit per byte register of the data buffer.
  localparam int unsigned VAS_WIDTH = 8;
endpackage

// File: rtl/vas_mask_chain.sv
// Mask chain: high from the top bit down to and including the highest
// set bit of the vector, low below it.
module vas_mask_chain #(
  parameter int unsigned W = vas_pkg::VAS_WIDTH
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] mask
);
  assign mask[W-1] = |vec;
  for (genvar j = 0; j < W - 1; j++) begin : g_chain
    assign mask[j] = mask[j+1] & ~vec[j+1];
  end
endmodule

// File: rtl/vas_select_net.sv
// Select network: an adjacent-mask XOR finds the edge of the mask, which
// sits at the highest set vector bit. The bottom bit is gated by the vector.
module vas_select_net #(
  parameter int unsigned W = vas_pkg::VAS_WIDTH
) (
  input  logic [W-1:0] mask,
  input  logic [W-1:0] vec,
  output logic [W-1:0] sel
);
  assign sel[0] = mask[0] & vec[0];
  for (genvar j = 0; j < W - 1; j++) begin : g_edge
    assign sel[j+1] = mask[j] ^ mask[j+1];
  end
endmodule

// File: rtl/vector_addr_sequencer.sv
module vector_addr_sequencer #(
  parameter int unsigned W = vas_pkg::VAS_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] sel_o,
  output logic         sel_valid_o,
  output logic         done_o
);
  logic [W-1:0] vec_q;
  logic [W-1:0] mask_q;
  logic         done_q;
  logic [W-1:0] sel;
  logic [W-1:0] vec_nxt;
  logic [W-1:0] mask_nxt;
  logic         busy;
  logic         accept;

  // Named internal events for the checker
  assign busy   = |vec_q;
  assign accept = load_i & ~busy;

  vas_select_net #(.W(W)) i_sel (
    .mask (mask_q),
    .vec  (vec_q),
    .sel  (sel)
  );

  always_comb begin
    if (accept)    vec_nxt = vec_i;
    else if (busy) vec_nxt = vec_q ^ sel;
    else           vec_nxt = vec_q;
  end

  vas_mask_chain #(.W(W)) i_mask (
    .vec  (vec_nxt),
    .mask (mask_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= '0;
      mask_q <= '0;
      done_q <= 1'b0;
    end else begin
      vec_q  <= vec_nxt;
      mask_q <= mask_nxt;
      if (accept || busy) done_q <= (vec_nxt == '0);
    end
  end

  assign sel_o       = sel;
  assign sel_valid_o = busy;
  assign done_o      = done_q;
endmodule

// File: rtl/vas_checker.sv
module vas_checker #(
  parameter int unsigned W = vas_pkg::VAS_WIDTH
) (
  input logic         clk,
  input logic         rst,
  input logic         load_i,
  input logic [W-1:0] vec_i,
  input logic [W-1:0] sel_o,
  input logic         sel_valid_o,
  input logic         done_o,
  input logic [W-1:0] vec_q,
  input logic         accept
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!done_o && !sel_valid_o && sel_o == '0));

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    sel_valid_o |-> $countones(sel_o) == 1);

  // R3
  sel_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_valid_o |-> sel_o == '0);

  // R4
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    sel_valid_o |=> (!sel_valid_o || sel_o < $past(sel_o)));

  // R5
  served_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_valid_o && !accept) |=> vec_q == ($past(vec_q) & ~$past(sel_o)));

  // R7
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && sel_valid_o) |=> vec_q == ($past(vec_q) ^ $past(sel_o)));

  // R6
  zero_load_done_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && vec_i == '0) |=> (done_o && !sel_valid_o));

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !sel_valid_o);
endmodule

bind vector_addr_sequencer vas_checker #(.W(W)) i_vas_checker (
  .clk         (clk),
  .rst         (rst),
  .load_i      (load_i),
  .vec_i       (vec_i),
  .sel_o       (sel_o),
  .sel_valid_o (sel_valid_o),
  .done_o      (done_o),
  .vec_q       (vec_q),
  .accept      (accept)
);

// File: tb/test_vector_addr_sequencer.sv
module test_vector_addr_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_i = 1'b0;
  logic [7:0] vec_i = '0;
  logic [7:0] sel_o;
  logic       sel_valid_o;
  logic       done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  vector_addr_sequencer i_vector_addr_sequencer (
    .clk(clk), .rst(rst), .load_i(load_i), .vec_i(vec_i),
    .sel_o(sel_o), .sel_valid_o(sel_valid_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected k-th select: scan from the top bit down, skip k set bits.
  function automatic logic [7:0] kth_sel(input logic [7:0] b, input int k);
    int seen = 0;
    for (int j = 7; j >= 0; j--) begin
      if (b[j]) begin
        if (seen == k) return 8'(1) << j;
        seen++;
      end
    end
    return 8'h00;
  endfunction

  function automatic int ones(input logic [7:0] b);
    int n = 0;
    for (int j = 0; j < 8; j++) n += int'(b[j]);
    return n;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", 32'(done_o), 0);
    check("R1 valid", 32'(sel_valid_o), 0);
    check("R1 sel", 32'(sel_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-release idle", 32'(sel_valid_o), 0);

    for (int b = 0; b < 256; b++) begin
      logic [7:0] acc;
      int p;
      acc = '0;
      p = ones(8'(b));
      load_i = 1'b1;
      vec_i = 8'(b);
      @(negedge clk);
      load_i = 1'b0;
      for (int k = 0; k < p; k++) begin
        // R2 R4: select order, one per cycle
        check("R4 sel order", 32'(sel_o), 32'(kth_sel(8'(b), k)));
        check("R3 valid", 32'(sel_valid_o), 1);
        check("R8 done low while busy", 32'(done_o), 0);
        acc ^= sel_o;
        if (k == 0 && p >= 2) begin
          // R7: load during a sequence must be ignored
          load_i = 1'b1;
          vec_i = ~8'(b);
        end
        @(negedge clk);
        load_i = 1'b0;
      end
      // R5: XOR of selects equals byte; R6: done right after
      check("R5 xor", 32'(acc), 32'(b));
      check("R6 done", 32'(done_o), 1);
      check("R6 no valid", 32'(sel_valid_o), 0);
      check("R3 sel zero idle", 32'(sel_o), 0);
      @(negedge clk);
      check("R6 done holds idle", 32'(done_o), 1);
    end

    // R1: reset mid-sequence clears state
    load_i = 1'b1; vec_i = 8'hA5;
    @(negedge clk);
    load_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset valid", 32'(sel_valid_o), 0);
    check("R1 mid reset done", 32'(done_o), 0);
    rst = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule